// File: doc/BRIEF.md
# Five-Bank Interleaved Span Writer

This block sits between a span renderer and a frame buffer built from five memory banks that are interleaved by pixel column. The renderer hands over one horizontal run of pixels at a time: a start column, a line number, a pixel count and a fill color. The block cuts the run into groups of up to five neighbouring pixels. It writes each group in a single cycle, one pixel per bank, and drives a bank-local address and a write enable for every bank.

Column x belongs to bank x mod 5. All five banks see the same local address y*256 + x/5, because one group always covers columns 5g to 5g+4. The quotient for the start column comes from a constant reciprocal multiply. After that the block only adds one to it for each group, so no divider is built. A run that starts or ends inside a group enables only the banks it covers. A run that reaches past the right edge of the screen is cut off at the last column. A run of length zero, or one that starts beyond the screen, is accepted and writes nothing.

Commands use a valid/ready handshake. The block can take the next command in the same cycle as the final group of the current run, so runs can follow each other with no idle cycle between them.

Top module: `vpw_pixel_writer`

## Requirements
- R1: While reset is asserted and after it is released with no command, every bank write enable is 0 and cmd_ready is 1.
- R2: Pixel (x, y) is written only on bank x mod NUM_BANKS, at local address y*BANK_W + x div NUM_BANKS, with BANK_W = SCREEN_W / NUM_BANKS. Bank b uses wr_addr bits [b*AW +: AW] and wr_data bits [b*COLOR_W +: COLOR_W].
- R3: A run whose clipped length is L and whose start column is x issues exactly ((x mod NUM_BANKS) + L - 1) div NUM_BANKS + 1 groups, one per cycle and with no gaps. The first group appears in the cycle that follows acceptance.
- R4: In the first and last groups of a run, only the banks holding covered columns are enabled. Every group after the first starts at bank 0.
- R5: Every column of a run is written exactly once, with the run's color. No other pixel is written.
- R6: Columns at or beyond SCREEN_W are never written. A run is clipped to columns x through SCREEN_W-1.
- R7: A command of length 0, or one whose start column is SCREEN_W or more, is accepted with no write in any later cycle.
- R8: cmd_ready is 0 during every group except the final one, and 1 during the final group and while idle. A command held valid during a run is accepted on that run's final group, and its first group follows in the next cycle.
- R9: The line number used for the addresses stays constant for the whole of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A run command is offered |
| cmd_ready | output | 1 | The offered command is taken at this edge |
| cmd_x | input | XW | Start column |
| cmd_y | input | YW | Line number |
| cmd_len | input | LENW | Pixel count |
| cmd_color | input | COLOR_W | Fill color |
| wr_en | output | NUM_BANKS | Per-bank write enable |
| wr_addr | output | NUM_BANKS*AW | Per-bank local address, bank b in slice b |
| wr_data | output | NUM_BANKS*COLOR_W | Per-bank write data, bank b in slice b |

## Verification
Issuing the final group of one run and accepting the next command can happen in the same cycle. This is provoked by keeping cmd_valid high with a second command, on a different line, while the first run is still being written. The second command must be accepted exactly one group count after the first. The writes of both runs must then form one unbroken train of cycles. Both lines must end up with each column written exactly once and in the right color, so that a lost, repeated or merged group shows up as a wrong hit count or a wrong color.

// File: rtl/vpw_pkg.sv
package vpw_pkg;
  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_t;
endpackage

// File: rtl/vpw_seg_plan.sv
// Start-of-run planning: group index, lane offset and clipped length.
module vpw_seg_plan #(
  parameter int N    = 5,
  parameter int W    = 1280,
  parameter int XW   = 11,
  parameter int LENW = 11,
  parameter int GW   = 8,
  parameter int LW   = 3
) (
  input  logic [XW-1:0]   cmd_x,
  input  logic [LENW-1:0] cmd_len,
  output logic [GW-1:0]   plan_grp,
  output logic [LW-1:0]   plan_lane,
  output logic [LENW-1:0] plan_len
);
  // Reciprocal with enough fraction bits that floor(x*RECIP >> S) == x / N
  // for every x below 2**XW.
  localparam int S     = XW + $clog2(N) + 1;
  localparam int RECIP = (2**S + N - 1) / N;
  localparam int PW    = XW + S;
  localparam logic [LENW-1:0] W_L = LENW'(W);

  logic [PW-1:0]   prod;
  logic [PW-1:0]   quo;
  logic [XW-1:0]   rem_x;
  logic [LENW-1:0] room;

  assign prod  = PW'(cmd_x) * PW'(RECIP);
  assign quo   = prod >> S;
  assign rem_x = cmd_x - XW'(quo[XW-1:0] * XW'(N));

  assign plan_grp  = quo[GW-1:0];
  assign plan_lane = rem_x[LW-1:0];

  always_comb begin
    room = W_L - LENW'(cmd_x);
    if (LENW'(cmd_x) >= W_L)  plan_len = '0;
    else if (cmd_len < room)  plan_len = cmd_len;
    else                      plan_len = room;
  end
endmodule

// File: rtl/vpw_group_seq.sv
// Group sequencer: walks a run one group per cycle and owns the handshake.
module vpw_group_seq
  import vpw_pkg::*;
#(
  parameter int N    = 5,
  parameter int GW   = 8,
  parameter int LW   = 3,
  parameter int LENW = 11,
  parameter int YW   = 10,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [GW-1:0]   plan_grp,
  input  logic [LW-1:0]   plan_lane,
  input  logic [LENW-1:0] plan_len,
  input  logic [YW-1:0]   cmd_y,
  input  logic [CW-1:0]   cmd_color,
  output logic            cmd_ready,
  output logic            run,
  output logic            last,
  output logic            load,
  output logic [GW-1:0]   grp_q,
  output logic [LW-1:0]   lane_q,
  output logic [LENW-1:0] rem_q,
  output logic [YW-1:0]   line_q,
  output logic [CW-1:0]   color_q
);
  eng_state_t      st_q, st_n;
  logic [LENW-1:0] rem_n;
  logic [GW-1:0]   grp_n;
  logic [LW-1:0]   lane_n;
  logic [LENW-1:0] span;
  logic            advance;
  logic            step_en;

  assign run       = (st_q == ENG_RUN);
  assign span      = LENW'(N) - LENW'(lane_q);
  assign last      = run && (rem_q <= span);
  assign advance   = run && !last;
  assign cmd_ready = !run || last;
  assign load      = cmd_valid && cmd_ready && (plan_len != '0);
  assign step_en   = load || advance;

  always_comb begin
    st_n   = st_q;
    rem_n  = rem_q;
    grp_n  = grp_q;
    lane_n = lane_q;
    if (advance) begin
      rem_n  = rem_q - span;
      grp_n  = grp_q + 1'b1;
      lane_n = '0;
    end else if (load) begin
      st_n   = ENG_RUN;
      rem_n  = plan_len;
      grp_n  = plan_grp;
      lane_n = plan_lane;
    end else begin
      st_n   = ENG_IDLE;
      rem_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      rem_q <= '0;
    end else begin
      st_q  <= st_n;
      rem_q <= rem_n;
    end
  end

  always_ff @(posedge clk) begin
    if (step_en) begin
      grp_q  <= grp_n;
      lane_q <= lane_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      line_q  <= cmd_y;
      color_q <= cmd_color;
    end
  end

  assert_grp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (grp_q == $past(grp_q) + 1'b1));

  assert_line_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> $stable(line_q));
endmodule

// File: rtl/vpw_bank_drive.sv
// Per-bank enable, address and data drive.
module vpw_bank_drive #(
  parameter int N     = 5,
  parameter int GW    = 8,
  parameter int LW    = 3,
  parameter int LENW  = 11,
  parameter int YW    = 10,
  parameter int CW    = 8,
  parameter int AW    = 18,
  parameter int BANKW = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [GW-1:0]   grp_q,
  input  logic [LW-1:0]   lane_q,
  input  logic [LENW-1:0] rem_q,
  input  logic [YW-1:0]   line_q,
  input  logic [CW-1:0]   color_q,
  output logic [N-1:0]    wr_en,
  output logic [N*AW-1:0] wr_addr,
  output logic [N*CW-1:0] wr_data
);
  logic [AW-1:0] addr;

  assign addr = AW'(line_q) * AW'(BANKW) + AW'(grp_q);

  for (genvar b = 0; b < N; b++) begin : g_bank
    localparam logic [LW-1:0] LANE = LW'(b);
    logic [LENW-1:0] off;
    assign off                  = LENW'(LANE - lane_q);
    assign wr_en[b]             = run && (LANE >= lane_q) && (off < rem_q);
    assign wr_addr[b*AW +: AW]  = addr;
    assign wr_data[b*CW +: CW]  = color_q;
  end

  assert_run_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (wr_en != '0));
endmodule

// File: rtl/vpw_pixel_writer.sv
module vpw_pixel_writer #(
  parameter  int NUM_BANKS = 5,
  parameter  int SCREEN_W  = 1280,
  parameter  int SCREEN_H  = 1024,
  parameter  int COLOR_W   = 8,
  localparam int BANK_W    = SCREEN_W / NUM_BANKS,
  localparam int XW        = $clog2(SCREEN_W),
  localparam int YW        = $clog2(SCREEN_H),
  localparam int LENW      = $clog2(SCREEN_W + 1),
  localparam int GW        = $clog2(BANK_W),
  localparam int LW        = $clog2(NUM_BANKS),
  localparam int AW        = $clog2(SCREEN_H * BANK_W)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [XW-1:0]                cmd_x,
  input  logic [YW-1:0]                cmd_y,
  input  logic [LENW-1:0]              cmd_len,
  input  logic [COLOR_W-1:0]           cmd_color,
  output logic [NUM_BANKS-1:0]         wr_en,
  output logic [NUM_BANKS*AW-1:0]      wr_addr,
  output logic [NUM_BANKS*COLOR_W-1:0] wr_data
);
  logic [GW-1:0]      plan_grp;
  logic [LW-1:0]      plan_lane;
  logic [LENW-1:0]    plan_len;
  logic               run, last, load;
  logic [GW-1:0]      grp_q;
  logic [LW-1:0]      lane_q;
  logic [LENW-1:0]    rem_q;
  logic [YW-1:0]      line_q;
  logic [COLOR_W-1:0] color_q;

  vpw_seg_plan #(
    .N(NUM_BANKS), .W(SCREEN_W), .XW(XW), .LENW(LENW), .GW(GW), .LW(LW)
  ) u_plan (
    .cmd_x(cmd_x), .cmd_len(cmd_len),
    .plan_grp(plan_grp), .plan_lane(plan_lane), .plan_len(plan_len)
  );

  vpw_group_seq #(
    .N(NUM_BANKS), .GW(GW), .LW(LW), .LENW(LENW), .YW(YW), .CW(COLOR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .plan_grp(plan_grp), .plan_lane(plan_lane), .plan_len(plan_len),
    .cmd_y(cmd_y), .cmd_color(cmd_color),
    .cmd_ready(cmd_ready), .run(run), .last(last), .load(load),
    .grp_q(grp_q), .lane_q(lane_q), .rem_q(rem_q),
    .line_q(line_q), .color_q(color_q)
  );

  vpw_bank_drive #(
    .N(NUM_BANKS), .GW(GW), .LW(LW), .LENW(LENW), .YW(YW), .CW(COLOR_W),
    .AW(AW), .BANKW(BANK_W)
  ) u_drive (
    .clk(clk), .rst_n(rst_n), .run(run),
    .grp_q(grp_q), .lane_q(lane_q), .rem_q(rem_q),
    .line_q(line_q), .color_q(color_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assert_first_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wr_en != '0));

  assert_next_from_bank0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> wr_en[0]);

  assert_zero_len_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !run && (plan_len == '0)) |=> (wr_en == '0));

  assert_ready_low_midrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en != '0) && !cmd_ready) |=> (wr_en != '0));
endmodule

// File: tb/tb_vpw_pixel_writer.sv
module tb_vpw_pixel_writer;
  localparam int N  = 5;
  localparam int W  = 40;
  localparam int H  = 4;
  localparam int CW = 8;
  localparam int BW = W / N;
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H);
  localparam int LENW = $clog2(W + 1);
  localparam int AW = $clog2(H * BW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [XW-1:0] cmd_x = '0;
  logic [YW-1:0] cmd_y = '0;
  logic [LENW-1:0] cmd_len = '0;
  logic [CW-1:0] cmd_color = '0;
  logic [N-1:0] wr_en;
  logic [N*AW-1:0] wr_addr;
  logic [N*CW-1:0] wr_data;

  always #5 clk = ~clk;

  vpw_pixel_writer #(.NUM_BANKS(N), .SCREEN_W(W), .SCREEN_H(H), .COLOR_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_len(cmd_len), .cmd_color(cmd_color),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int en_cycles = 0;
  int last_en_cyc = -1;
  int ready_low = 0;
  int bad_addr = 0;
  int hits [H][W];
  int got_col [H][W];
  int exp_hits [H][W];
  int exp_col [H][W];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Decodes every bank write back to a screen position (R2).
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cmd_ready) ready_low++;
      if (wr_en != '0) begin
        en_cycles++;
        last_en_cyc = cyc;
      end
      for (int b = 0; b < N; b++) begin
        if (wr_en[b]) begin
          int a, ln, col;
          a = int'(wr_addr[b*AW +: AW]);
          ln = a / BW;
          col = (a % BW) * N + b;
          if (ln < H && col < W) begin
            hits[ln][col]++;
            got_col[ln][col] = int'(wr_data[b*CW +: CW]);
          end else bad_addr++;
        end
      end
    end
  end

  function automatic int eff_of(input int x, input int len);
    if (x >= W) return 0;
    return (len < W - x) ? len : W - x;
  endfunction

  function automatic int groups_of(input int x, input int len);
    int e;
    e = eff_of(x, len);
    if (e == 0) return 0;
    return ((x % N) + e - 1) / N + 1;
  endfunction

  task automatic clear_maps();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        hits[r][c] = 0; got_col[r][c] = -1; exp_hits[r][c] = 0; exp_col[r][c] = -1;
      end
    en_cycles = 0; last_en_cyc = -1; ready_low = 0; bad_addr = 0;
  endtask

  task automatic expect_run(input int x, input int y, input int len, input int col);
    for (int i = 0; i < eff_of(x, len); i++) begin
      exp_hits[y][x+i] = 1;
      exp_col[y][x+i] = col;
    end
  endtask

  // Leaves cmd_valid high; returns the cycle number of the accepting edge.
  task automatic send(input int x, input int y, input int len, input int col,
                      output int acc);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_x = XW'(x); cmd_y = YW'(y); cmd_len = LENW'(len); cmd_color = CW'(col);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 acc = cyc;
  endtask

  task automatic finish_run();
    @(negedge clk);
    cmd_valid = 1'b0;
    while (wr_en != '0) @(negedge clk);
    @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic check_maps(input string tag);
    int bad_h, bad_c, fr, fc;
    bad_h = 0; bad_c = 0; fr = 0; fc = 0;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        if (hits[r][c] != exp_hits[r][c]) begin
          if (bad_h == 0) begin fr = r; fc = c; end
          bad_h++;
        end else if (exp_hits[r][c] == 1 && got_col[r][c] != exp_col[r][c]) bad_c++;
      end
    chk(bad_h == 0, tag, $sformatf("hit count at line %0d col %0d", fr, fc),
        hits[fr][fc], exp_hits[fr][fc]);
    chk(bad_c == 0, tag, "pixels with wrong color (R2 R5)", bad_c, 0);
    chk(bad_addr == 0, "R6", "writes outside the screen", bad_addr, 0);
  endtask

  task automatic single(input int x, input int y, input int len, input int col);
    int acc, g, e;
    string tag;
    clear_maps();
    expect_run(x, y, len, col);
    g = groups_of(x, len);
    e = eff_of(x, len);
    send(x, y, len, col, acc);
    finish_run();
    if (e == 0) tag = "R7";
    else if (e < len) tag = "R6";
    else if ((x % N) != 0 || ((x + e) % N) != 0) tag = "R4";
    else tag = "R5";
    check_maps(tag);
    chk(en_cycles == g, "R3", "write cycles", en_cycles, g);
    if (g > 0) begin
      chk(last_en_cyc == acc + g - 1, "R3", "cycle of final group", last_en_cyc, acc + g - 1);
      chk(ready_low == g - 1, "R8", "cycles with ready low", ready_low, g - 1);
    end
  endtask

  task automatic pair(input int xa, input int la, input int xb, input int lb, input int y);
    int acc_a, acc_b, ga, gb, yb;
    yb = (y + 1) % H;
    clear_maps();
    expect_run(xa, y, la, 8'h3c);
    expect_run(xb, yb, lb, 8'hc5);
    ga = groups_of(xa, la);
    gb = groups_of(xb, lb);
    send(xa, y, la, 8'h3c, acc_a);
    send(xb, yb, lb, 8'hc5, acc_b);
    finish_run();
    // final group of the first run and acceptance of the second share a cycle
    chk(acc_b == acc_a + ga, "R8", "accept of queued command", acc_b, acc_a + ga);
    chk(last_en_cyc == acc_a + ga + gb - 1, "R3", "unbroken write train end",
        last_en_cyc, acc_a + ga + gb - 1);
    chk(en_cycles == ga + gb, "R9", "write cycles of two runs", en_cycles, ga + gb);
    check_maps("R9");
  endtask

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3;
    chk(wr_en == '0, "R1", "enables during reset", int'(wr_en), 0);
    chk(cmd_ready == 1'b1, "R1", "ready during reset", int'(cmd_ready), 1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(wr_en == '0, "R1", "enables after reset", int'(wr_en), 0);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
    @(posedge clk);
    #1;
    // Near-exhaustive sweep of start column and length, including off-screen starts.
    for (int x = 0; x < W + 3; x++)
      for (int len = 0; len <= W + 1; len++)
        single(x, x % H, len, (x * 7 + len * 13 + 1) & 8'hff);
    // Back-to-back runs across lane offsets and lengths.
    for (int xa = 0; xa < W; xa += 3)
      for (int la = 1; la <= 12; la += 5)
        pair(xa, la, (xa * 3) % W, (la * 2 + 1) % 15, xa % H);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule